// File: doc/BRIEF.md
# Table-driven serial pattern detector

This block watches a one-bit serial stream and raises a single-cycle flag each time the stream completes the bit sequence 0,1,1,0,1,1. Instead of next-state gates, it uses a fixed 16-word by 4-bit lookup table. The table's address is the incoming bit joined to the current 3-bit state code. Each word carries the next state code and the flag value that goes with it.

A clocked register captures the table word on every rising edge. The state field of that register is fed back as the upper part of the next address. The address path itself has no register, so the only storage in the loop is the output register. The block has no reset input. The register and the table contents come up from initial values: the register powers up holding the idle code with the flag low, and the table is computed at elaboration.

The machine has seven states:

| State | Code |
|---|---|
| idle (`ST_IDLE`) | 0 |
| got-0 (`ST_GOT0`) | 1 |
| got-01 (`ST_GOT01`) | 2 |
| got-011 (`ST_GOT011`) | 3 |
| got-0110 (`ST_GOT0110`) | 4 |
| got-01101 (`ST_GOT01101`) | 5 |
| full match (`ST_FULL`) | 6 |

Code 7 is spare.

The transitions are:

- idle: 0 goes to got-0; 1 stays in idle.
- got-0: 1 goes to got-01.
- got-01: 1 goes to got-011.
- got-011: 0 goes to got-0110.
- got-0110: 1 goes to got-01101.
- got-01101: 1 goes to full match.
- full match: 0 goes to got-0110; 1 goes to idle.
- Every other input returns to idle.

Top module: `pattern_lut_detector`

## Requirements
- R1: With no reset applied, match reads 0 from time zero, and the machine starts in idle, so the first complete 0,1,1,0,1,1 on serial_in is detected.
- R2: When serial_in carries 0,1,1,0,1,1 on six consecutive rising edges starting from idle, match is 1 during the clock cycle that follows the edge that sampled the sixth bit.
- R3: Each detection drives match high for exactly one clock cycle.
- R4: match is 1 only in the cycle right after an edge that sampled serial_in = 1 while the machine was in got-01101; it is 0 in every other state.
- R5: In idle, serial_in = 1 keeps the machine in idle and 0 moves it to got-0. In got-0 through got-01101, a bit other than the expected one returns the machine to idle without reusing any part of the prefix, so the stream 0,0,1,1,0,1,1 gives no match.
- R6: The spare state code 7 leads to idle with match 0 for both input values, and it is never entered.
- R7: From full match, serial_in = 0 moves to got-0110, so 0,1,1,0,1,1,0,1,1 gives two pulses, on the sixth and ninth bits. serial_in = 1 returns to idle.
- R8: The stream 0,1,1,1,0,1 never produces a match.
- R9: The lookup is a 16 x 4 table addressed by {serial_in, state[2:0]} whose word is {match, next[2:0]}; only its registered output is visible, so a change of serial_in between clock edges does not change match until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the output register loads on the rising edge |
| serial_in | input | 1 | Serial data bit, sampled on each rising edge |
| match | output | 1 | High for one cycle after the sequence 0,1,1,0,1,1 completes |

## Verification
The hardest situation to reach from the ports is the spare state code. There is no reset, and no input sequence can steer the machine into code 7, so its table entries can never be exercised by stimulus. Its effect is instead guarded by a clocked property stating that the registered state never takes the spare code.

The overlap path from full match back into got-0110 is reached by feeding back-to-back patterns that share their last three bits. The prefix-restart rule is reached with a doubled leading zero. A long pseudo-random stream, compared against a bench model of the transition rules, reaches every state under both input values.

// File: rtl/pattern_lut_pkg.sv
`timescale 1ns/1ps
package pattern_lut_pkg;

    localparam int STATE_W = 3;
    localparam int ADDR_W  = 1 + STATE_W;   // {serial bit, current state}
    localparam int WORD_W  = 1 + STATE_W;   // {match, next state}
    localparam int DEPTH   = 1 << ADDR_W;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE     = 3'd0,
        ST_GOT0     = 3'd1,
        ST_GOT01    = 3'd2,
        ST_GOT011   = 3'd3,
        ST_GOT0110  = 3'd4,
        ST_GOT01101 = 3'd5,
        ST_FULL     = 3'd6
    } det_state_t;

    // One table word for a given address; evaluated at elaboration only.
    function automatic logic [WORD_W-1:0] lut_entry(input logic [ADDR_W-1:0] addr);
        logic                  din;
        logic [STATE_W-1:0]    cur;
        logic [STATE_W-1:0]    nxt;
        din = addr[ADDR_W-1];
        cur = addr[STATE_W-1:0];
        case (cur)
            ST_IDLE:     nxt = din ? ST_IDLE     : ST_GOT0;
            ST_GOT0:     nxt = din ? ST_GOT01    : ST_IDLE;
            ST_GOT01:    nxt = din ? ST_GOT011   : ST_IDLE;
            ST_GOT011:   nxt = din ? ST_IDLE     : ST_GOT0110;
            ST_GOT0110:  nxt = din ? ST_GOT01101 : ST_IDLE;
            ST_GOT01101: nxt = din ? ST_FULL     : ST_IDLE;
            ST_FULL:     nxt = din ? ST_IDLE     : ST_GOT0110;  // R7 overlap
            default:     nxt = ST_IDLE;                          // R6 spare code
        endcase
        return {(nxt == ST_FULL), nxt};
    endfunction

endpackage

// File: rtl/pattern_lut_rom.sv
`timescale 1ns/1ps
// Fixed lookup table, unregistered address, contents computed at elaboration (R9).
module pattern_lut_rom
    import pattern_lut_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = WORD_W
) (
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_word
);
    localparam int N_WORDS = 1 << AW;

    logic [DW-1:0] table_w [N_WORDS];

    for (genvar a = 0; a < N_WORDS; a++) begin : g_word
        assign table_w[a] = lut_entry(a[AW-1:0]);
    end

    assign rd_word = table_w[rd_addr];
endmodule

// File: rtl/pattern_lut_oreg.sv
`timescale 1ns/1ps
// Output register of the table; powers up to INIT since no reset exists (R1).
module pattern_lut_oreg #(
    parameter int          W    = 4,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] q_r = INIT;

    always_ff @(posedge clk) begin
        q_r <= d;
    end

    assign q = q_r;
endmodule

// File: rtl/pattern_lut_detector.sv
`timescale 1ns/1ps
module pattern_lut_detector
    import pattern_lut_pkg::*;
(
    input  logic clk,
    input  logic serial_in,
    output logic match
);
    localparam logic [WORD_W-1:0] POWER_UP = {1'b0, ST_IDLE};

    logic [STATE_W-1:0] state_q;
    logic [ADDR_W-1:0]  lut_addr;
    logic [WORD_W-1:0]  lut_word;
    logic [WORD_W-1:0]  reg_word;

    // Address: incoming bit on top, fed-back state below.
    assign lut_addr = {serial_in, state_q};

    pattern_lut_rom #(
        .AW (ADDR_W),
        .DW (WORD_W)
    ) rom_i (
        .rd_addr (lut_addr),
        .rd_word (lut_word)
    );

    pattern_lut_oreg #(
        .W    (WORD_W),
        .INIT (POWER_UP)
    ) oreg_i (
        .clk (clk),
        .d   (lut_word),
        .q   (reg_word)
    );

    assign state_q = reg_word[STATE_W-1:0];
    assign match   = reg_word[WORD_W-1];
endmodule

// File: rtl/pattern_lut_detector_chk.sv
`timescale 1ns/1ps
module pattern_lut_detector_chk
    import pattern_lut_pkg::*;
(
    input logic               clk,
    input logic               serial_in,
    input logic               match,
    input logic [STATE_W-1:0] state_q
);
    // No reset: gate the properties until one edge has passed.
    logic warm = 1'b0;
    always_ff @(posedge clk) warm <= 1'b1;

    p_single_pulse_r3: assert property (@(posedge clk) disable iff (!warm)
        match |=> !match);

    p_match_cause_r4: assert property (@(posedge clk) disable iff (!warm)
        match |-> ($past(state_q) == ST_GOT01101 && $past(serial_in)));

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!warm)
        (state_q == ST_IDLE && serial_in) |=> (state_q == ST_IDLE && !match));

    p_bad_bit_r5: assert property (@(posedge clk) disable iff (!warm)
        (state_q == ST_GOT0 && !serial_in) |=> (state_q == ST_IDLE));

    p_no_spare_code_r6: assert property (@(posedge clk) disable iff (!warm)
        state_q != 3'd7);

    p_overlap_r7: assert property (@(posedge clk) disable iff (!warm)
        (state_q == ST_FULL && !serial_in) |=> (state_q == ST_GOT0110));

    p_match_state_r4: assert property (@(posedge clk) disable iff (!warm)
        (state_q != ST_FULL) |-> !match);
endmodule

bind pattern_lut_detector pattern_lut_detector_chk chk_i (
    .clk       (clk),
    .serial_in (serial_in),
    .match     (match),
    .state_q   (state_q)
);

// File: tb/pattern_lut_detector_tb_top.sv
`timescale 1ns/1ps
module pattern_lut_detector_tb_top;

    logic clk = 1'b0;
    logic serial_in = 1'b1;
    logic match;

    int n_chk = 0;
    int n_bad = 0;
    int mdl   = 0;     // bench model state: number of pattern bits held (0..6)
    int pulses;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    pattern_lut_detector dut_i (
        .clk       (clk),
        .serial_in (serial_in),
        .match     (match)
    );

    function automatic int mdl_next(input int s, input logic b);
        case (s)
            0: return b ? 0 : 1;
            1: return b ? 2 : 0;
            2: return b ? 3 : 0;
            3: return b ? 0 : 4;
            4: return b ? 5 : 0;
            5: return b ? 6 : 0;
            6: return b ? 0 : 4;
            default: return 0;
        endcase
    endfunction

    task automatic check(input logic got, input logic exp, input string req);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: match=%0b expected=%0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic drive_bit(input logic b, input string req);
        @(negedge clk);
        serial_in = b;
        mdl = mdl_next(mdl, b);
        @(posedge clk);
        #1;
        check(match, (mdl == 6), req);
        if (match === 1'b1) pulses++;
    endtask

    task automatic drive_str(input string s, input string req);
        for (int i = 0; i < s.len(); i++) drive_bit(s[i] == "1", req);
    endtask

    task automatic flush();
        drive_str("111", "R5");
    endtask

    task automatic t_powerup();
        #1;
        check(match, 1'b0, "R1");
        drive_str("11", "R1");
    endtask

    task automatic t_single();
        pulses = 0;
        drive_str("011011", "R2");
        check(pulses == 1, 1'b1, "R3");
        drive_bit(1'b1, "R3");
        check(match, 1'b0, "R3");
    endtask

    task automatic t_near_miss();
        flush();
        pulses = 0;
        drive_str("011101", "R8");
        check(pulses != 0, 1'b0, "R8");
    endtask

    task automatic t_restart();
        flush();
        pulses = 0;
        drive_str("0011011", "R5");
        check(pulses != 0, 1'b0, "R5");
    endtask

    task automatic t_overlap();
        flush();
        pulses = 0;
        drive_str("011011011", "R7");
        check(pulses == 2, 1'b1, "R7");
        pulses = 0;
        drive_str("11011", "R7");
        check(pulses != 0, 1'b0, "R7");
    endtask

    task automatic t_midcycle();
        flush();
        drive_str("01101", "R9");
        drive_bit(1'b1, "R9");
        #0.5 serial_in = 1'b0;
        #0.3 check(match, 1'b1, "R9");
        drive_bit(1'b1, "R9");
        #0.5 serial_in = 1'b0;
        #0.3 check(match, 1'b0, "R9");
    endtask

    task automatic t_stream();
        logic [15:0] lfsr = 16'hACE1;
        flush();
        for (int i = 0; i < 800; i++) begin
            drive_bit(lfsr[0], "R4");
            lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
        end
    endtask

    initial begin
        t_powerup();
        t_single();
        t_near_miss();
        t_restart();
        t_overlap();
        t_midcycle();
        t_stream();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule